// File: doc/BRIEF.md
# I2C Slave Controller with Control/Status Register

This block is the target side of an I2C link, attached to a small processor through a register port. It synchronises the incoming SCL and SDA lines and finds start and stop conditions on them. After a start it shifts in the first byte. It answers when the upper seven bits equal a programmable own address, or when the whole byte is zero (general call). Once addressed, it either receives bytes and acknowledges them, or sends bytes taken from its data register, as the read/write bit asks. Both bus lines are open drain: the block only asks for a line to be pulled low.

A single byte-wide register combines three writable controls with five status flags. The flags are bus busy, address hit, general call, transfer direction, and the level seen on the last ninth clock. At the end of every byte the block handles, it can raise an interrupt and keep SCL low until the processor touches the data register.

Register offsets on the processor port:
- 0: control/status, bits 7..0 = {ack_en, mod_en, irq_en, gcall, xmit, busy, hit, last9}.
- 1: own address, in bits 6..0 (bit 7 reads 0).
- 2: data. A read returns the last byte received; a write loads the next byte to send.

Top module: `iic_slave_ctl`

## Requirements
- R1: After reset the control/status register reads 0x00, the own-address register reads 0x00, and irq_o, scl_low_o and sda_low_o are 0.
- R2: Bits 7..5 of offset 0 (ack_en, mod_en, irq_en) are read/write. Writes to bits 4..0 have no effect, so writing 0xFF while idle reads back 0xE0.
- R3: While mod_en (bit 6) is 0 the block ignores the bus. busy stays 0, no acknowledge is driven, and both line drives are released.
- R4: busy (bit 2) becomes 1 on a start condition (SDA falling while SCL is high). It returns to 0 on a stop condition (SDA rising while SCL is high).
- R5: hit (bit 1) is set when the upper seven bits of the first byte after a start equal the own-address register. Start and stop clear it. An address that is neither a hit nor a general call gets no acknowledge and no interrupt.
- R6: gcall (bit 4) is set when the first byte after a start is 0x00. That byte is then handled like a write to this slave. Start and stop clear gcall.
- R7: xmit (bit 3) takes the value of bit 0 (R/W) of an address byte that hits: 0 means the slave receives and 1 means it sends. Stop does not change it.
- R8: When ack_en (bit 7) is 1, the slave pulls SDA low during the ninth clock of an address byte that hits and of every byte it receives. When ack_en is 0 it never pulls SDA low in that slot.
- R9: last9 (bit 0) holds the SDA level sampled on the ninth rising SCL edge of the most recent byte the slave handled: 0 for acknowledge, 1 for no acknowledge.
- R10: When irq_en (bit 5) is 1, the falling SCL edge that ends the ninth clock of a handled byte sets irq_o and makes the slave hold SCL low. When irq_en is 0, irq_o stays 0 and SCL is never held.
- R11: A read or write of the data register (offset 2) clears irq_o and releases SCL. A read returns the last byte received.
- R12: In send mode the data register goes out MSB first, and SDA changes only while SCL is low. A no-acknowledge from the master ends the transfer, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | 1 = pull SCL low |
| sda_low_o | output | 1 | 1 = pull SDA low |
| irq_o | output | 1 | Byte-boundary interrupt |

## Verification
The bench uses the default values BUS_AW = 2 and SYNC_STAGES = 2. With these, all three register offsets are reachable, and the total lag from a line change to a registered drive is four clocks. The bench master holds each SCL quarter-period for eight clocks. That is long enough for acknowledge and data drives to settle inside the low phase, and tight enough that a drive one cycle late, or one changed while SCL is high, shows up at the sample point. Own addresses, non-matching addresses and payload bytes come from a seeded random source. General call, a refused acknowledge, a disabled interrupt, a disabled module and a master no-acknowledge are driven as directed cases.

// File: rtl/iic_slave_pkg.sv
package iic_slave_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR7_W = 7;

  localparam int OFS_CTL = 0;
  localparam int OFS_OWN = 1;
  localparam int OFS_DAT = 2;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_ADDR,
    ENG_RX,
    ENG_TX,
    ENG_SKIP
  } eng_state_t;

  // status half of the control/status register, bit 4 down to bit 0
  typedef struct packed {
    logic gcall;
    logic xmit;
    logic busy;
    logic hit;
    logic last9;
  } stat_t;
endpackage

// File: rtl/iic_slave_sync.sv
module iic_slave_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] now,
  output logic [WIDTH-1:0] prev
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-1:0], raw[g]};
    end
    assign now[g]  = chain[STAGES-1];
    assign prev[g] = chain[STAGES];
  end
endmodule

// File: rtl/iic_slave_regs.sv
module iic_slave_regs
  import iic_slave_pkg::*;
#(
  parameter int BUS_AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  stat_t             stat,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              ack_en,
  output logic              mod_en,
  output logic              irq_en,
  output logic [ADR7_W-1:0] own_addr,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              data_acc
);
  logic [2:0] ctl_q;
  logic       sel_ctl, sel_own, sel_dat;

  assign sel_ctl  = int'(bus_addr) == OFS_CTL;
  assign sel_own  = int'(bus_addr) == OFS_OWN;
  assign sel_dat  = int'(bus_addr) == OFS_DAT;
  assign data_acc = bus_sel && sel_dat;

  assign ack_en = ctl_q[2];
  assign mod_en = ctl_q[1];
  assign irq_en = ctl_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      own_addr <= '0;
      tx_byte  <= '0;
    end else if (bus_sel && bus_wr) begin
      if (sel_ctl) ctl_q    <= bus_wdata[BYTE_W-1 -: 3];
      if (sel_own) own_addr <= bus_wdata[ADR7_W-1:0];
      if (sel_dat) tx_byte  <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      if (sel_ctl)      bus_rdata <= {ctl_q, stat};
      else if (sel_own) bus_rdata <= {{(BYTE_W-ADR7_W){1'b0}}, own_addr};
      else if (sel_dat) bus_rdata <= rx_byte;
      else              bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/iic_slave_eng.sv
module iic_slave_eng
  import iic_slave_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_now,
  input  logic              scl_prev,
  input  logic              sda_now,
  input  logic              sda_prev,
  input  logic              mod_en,
  input  logic              ack_en,
  input  logic              irq_en,
  input  logic [ADR7_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              data_acc,
  output stat_t             stat,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              flag_o,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              evt_start,
  output logic              evt_stop
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);

  eng_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic              got_rise;
  logic [BYTE_W-1:0] sh;
  logic              flag, flag_d;

  logic scl_rise, scl_fall, in_xfer, adr_hit, byte_done, raise;
  logic sh_hit, sh_gc, drive_w;

  assign evt_start = scl_now & scl_prev & sda_prev & ~sda_now;
  assign evt_stop  = scl_now & scl_prev & ~sda_prev & sda_now;
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign in_xfer   = (state == ENG_ADDR) || (state == ENG_RX) || (state == ENG_TX);
  assign adr_hit   = stat.hit | stat.gcall;
  assign byte_done = scl_fall & got_rise & in_xfer & (cnt == ACK_SLOT);
  assign raise     = byte_done & ((state != ENG_ADDR) | adr_hit);
  assign sh_hit    = sh[BYTE_W-1:1] == own_addr;
  assign sh_gc     = sh == '0;

  // what SDA should be during the slot indexed by cnt
  always_comb begin
    unique case (state)
      ENG_ADDR: drive_w = (cnt == ACK_SLOT) && adr_hit && ack_en;
      ENG_RX:   drive_w = (cnt == ACK_SLOT) && ack_en;
      ENG_TX:   drive_w = (cnt != ACK_SLOT) && !tx_byte[~cnt[IDX_W-1:0]];
      default:  drive_w = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !mod_en) begin
      state     <= ENG_IDLE;
      cnt       <= '0;
      got_rise  <= 1'b0;
      sh        <= '0;
      stat      <= '0;
      rx_byte   <= '0;
      sda_low_o <= 1'b0;
    end else if (evt_start || evt_stop) begin
      state      <= evt_start ? ENG_ADDR : ENG_IDLE;
      cnt        <= '0;
      got_rise   <= 1'b0;
      stat.busy  <= evt_start;
      stat.gcall <= 1'b0;
      stat.hit   <= 1'b0;
      sda_low_o  <= 1'b0;
    end else begin
      if (!scl_now) sda_low_o <= drive_w;
      if (scl_rise && in_xfer) begin
        got_rise <= 1'b1;
        if (cnt != ACK_SLOT)
          sh <= {sh[BYTE_W-2:0], sda_now};
        else if (state != ENG_ADDR || adr_hit)
          stat.last9 <= sda_now;
      end
      if (scl_fall && got_rise && in_xfer) begin
        got_rise <= 1'b0;
        if (cnt == LAST_DATA) begin
          if (state == ENG_ADDR) begin
            stat.hit   <= sh_hit;
            stat.gcall <= sh_gc;
            if (sh_hit || sh_gc) stat.xmit <= sh[0];
          end else if (state == ENG_RX) begin
            rx_byte <= sh;
          end
        end
        if (cnt == ACK_SLOT) begin
          cnt <= '0;
          if (state == ENG_ADDR)
            state <= !adr_hit ? ENG_SKIP : (stat.xmit ? ENG_TX : ENG_RX);
          else if (state == ENG_TX && stat.last9)
            state <= ENG_SKIP;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // byte-boundary flag; SCL release trails the clear by two cycles so a new
  // transmit bit is on SDA before SCL is let go
  always_ff @(posedge clk) begin
    if (rst || !mod_en || !irq_en) begin
      flag <= 1'b0;
    end else if (raise) begin
      flag <= 1'b1;
    end else if (data_acc) begin
      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_d    <= 1'b0;
      scl_low_o <= 1'b0;
    end else begin
      flag_d    <= flag;
      scl_low_o <= flag | flag_d;
    end
  end

  assign flag_o = flag;
endmodule

// File: rtl/iic_slave_ctl.sv
module iic_slave_ctl
  import iic_slave_pkg::*;
#(
  parameter int BUS_AW      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              irq_o
);
  logic [1:0]        line_now, line_prev;
  logic              scl_now, scl_prev, sda_now, sda_prev;
  logic              ack_en, mod_en, irq_en, data_acc;
  logic [ADR7_W-1:0] own_addr;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  stat_t             stat;
  logic              evt_start, evt_stop;

  iic_slave_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .raw  ({scl_i, sda_i}),
    .now  (line_now),
    .prev (line_prev)
  );

  assign scl_now  = line_now[1];
  assign sda_now  = line_now[0];
  assign scl_prev = line_prev[1];
  assign sda_prev = line_prev[0];

  iic_slave_regs #(.BUS_AW(BUS_AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .stat      (stat),
    .rx_byte   (rx_byte),
    .ack_en    (ack_en),
    .mod_en    (mod_en),
    .irq_en    (irq_en),
    .own_addr  (own_addr),
    .tx_byte   (tx_byte),
    .data_acc  (data_acc)
  );

  iic_slave_eng u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_now   (scl_now),
    .scl_prev  (scl_prev),
    .sda_now   (sda_now),
    .sda_prev  (sda_prev),
    .mod_en    (mod_en),
    .ack_en    (ack_en),
    .irq_en    (irq_en),
    .own_addr  (own_addr),
    .tx_byte   (tx_byte),
    .data_acc  (data_acc),
    .stat      (stat),
    .rx_byte   (rx_byte),
    .flag_o    (irq_o),
    .scl_low_o (scl_low_o),
    .sda_low_o (sda_low_o),
    .evt_start (evt_start),
    .evt_stop  (evt_stop)
  );
endmodule

// File: rtl/iic_slave_chk.sv
module iic_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       mod_en,
  input logic       irq_en,
  input logic       evt_start,
  input logic       evt_stop,
  input logic       scl_now,
  input logic [4:0] stat_bits,
  input logic       irq,
  input logic       scl_low,
  input logic       sda_low
);
  logic busy, hit, gcall;
  assign gcall = stat_bits[4];
  assign busy  = stat_bits[2];
  assign hit   = stat_bits[1];

  // R1: reset leaves every output and the busy flag quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq && !scl_low && !sda_low && !busy));

  // R3: a disabled module releases SDA and is never busy
  p_disabled_release_r3: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> (!sda_low && !busy));

  // R4, R5, R6: start sets busy and clears the address flags
  p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (mod_en && evt_start) |=> (busy && !hit && !gcall));

  // R4, R5, R6: stop clears busy and the address flags
  p_stop_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (mod_en && evt_stop) |=> (!busy && !hit && !gcall));

  // R10: with the interrupt disabled the flag stays low
  p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  // R12: the SDA drive never moves while SCL is high
  p_sda_steady_r12: assert property (@(posedge clk) disable iff (rst)
    ($past(scl_now) && $past(mod_en) && !$past(rst) &&
     !$past(evt_start) && !$past(evt_stop)) |-> $stable(sda_low));
endmodule

bind iic_slave_ctl iic_slave_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mod_en    (mod_en),
  .irq_en    (irq_en),
  .evt_start (evt_start),
  .evt_stop  (evt_stop),
  .scl_now   (scl_now),
  .stat_bits (stat),
  .irq       (irq_o),
  .scl_low   (scl_low_o),
  .sda_low   (sda_low_o)
);

// File: tb/iic_slave_ctl_bench.sv
module iic_slave_ctl_bench;
  localparam int QTR = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_low, sda_low, irq;
  logic       scl_line, sda_line;
  int         n_chk = 0, n_fail = 0;

  assign scl_line = scl_m & ~scl_low;
  assign sda_line = sda_m & ~sda_low;

  always #5 clk = ~clk;

  iic_slave_ctl u_iic_slave_ctl (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .scl_i     (scl_line),
    .sda_i     (sda_line),
    .scl_low_o (scl_low),
    .sda_low_o (sda_low),
    .irq_o     (irq)
  );

  function automatic logic [7:0] exp_reg(input logic [2:0] c, input logic gc, tx, bsy, ht, l9);
    return {c, gc, tx, bsy, ht, l9};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_scl_high(); qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; wait_scl_high(); qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic bit_xfer(input logic b, output logic seen);
    sda_m = b; qwait();
    scl_m = 1'b1; wait_scl_high(); qwait();
    seen = sda_line; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack_seen);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
    bit_xfer(1'b1, ack_seen);
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      d[i] = s;
    end
    bit_xfer(mack, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rd, got, b;
    logic [6:0] own, other;
    logic       ack;
    void'($urandom(32'h1C2D3E4F));
    own = 7'($urandom()) | 7'h01;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cpu_rd(2'd0, rd); check("R1 ctl reset", rd, 8'h00);
    cpu_rd(2'd1, rd); check("R1 own reset", rd, 8'h00);
    check("R1 outputs reset", {5'd0, irq, scl_low, sda_low}, 8'h00);

    cpu_wr(2'd0, 8'hFF); cpu_rd(2'd0, rd); check("R2 status bits read-only", rd, 8'hE0);
    cpu_wr(2'd1, {1'b1, own}); cpu_rd(2'd1, rd); check("R2 own address", rd, {1'b0, own});

    // addressed write with random payload
    bus_start();
    cpu_rd(2'd0, rd); check("R4 busy after start", rd, exp_reg(3'b111, 0, 0, 1, 0, 0));
    send_byte({own, 1'b0}, ack);
    check("R8 ack on address hit", {7'd0, ack}, 8'h00);
    cpu_rd(2'd0, rd); check("R5 R7 R9 status after hit", rd, exp_reg(3'b111, 0, 0, 1, 1, 0));
    check("R10 irq and SCL hold", {6'd0, irq, scl_low}, 8'h03);
    cpu_rd(2'd2, rd); repeat (3) @(negedge clk);
    check("R11 irq cleared and SCL released", {6'd0, irq, scl_low}, 8'h00);
    for (int k = 0; k < 4; k++) begin
      b = 8'($urandom());
      send_byte(b, ack);
      check("R8 ack on data", {7'd0, ack}, 8'h00);
      check("R10 irq after data byte", {7'd0, irq}, 8'h01);
      cpu_rd(2'd2, rd); check("R11 received byte", rd, b);
      @(negedge clk); check("R11 irq cleared by read", {7'd0, irq}, 8'h00);
    end
    bus_stop();
    cpu_rd(2'd0, rd); check("R4 R5 stop clears busy and hit", rd, exp_reg(3'b111, 0, 0, 0, 0, 0));

    // slave transmit, master acks then nacks
    bus_start();
    send_byte({own, 1'b1}, ack);
    check("R8 ack on read address", {7'd0, ack}, 8'h00);
    cpu_rd(2'd0, rd); check("R7 xmit from R/W", rd, exp_reg(3'b111, 0, 1, 1, 1, 0));
    b = 8'($urandom()) | 8'h81;
    cpu_wr(2'd2, b);
    recv_byte(got, 1'b0);
    check("R12 first sent byte", got, b);
    check("R10 irq after sent byte", {7'd0, irq}, 8'h01);
    b = 8'($urandom()) & 8'h7E;
    cpu_wr(2'd2, b);
    recv_byte(got, 1'b1);
    check("R12 second sent byte", got, b);
    cpu_rd(2'd0, rd); check("R9 nack latched", rd, exp_reg(3'b111, 0, 1, 1, 1, 1));
    cpu_rd(2'd2, rd); repeat (4) @(negedge clk);
    check("R12 SDA released after nack", {7'd0, sda_low}, 8'h00);
    bus_stop();
    cpu_rd(2'd0, rd); check("R7 xmit kept after stop", rd, exp_reg(3'b111, 0, 1, 0, 0, 1));

    // general call
    bus_start();
    send_byte(8'h00, ack);
    check("R6 general call acked", {7'd0, ack}, 8'h00);
    cpu_rd(2'd0, rd); check("R6 gcall set", rd, exp_reg(3'b111, 1, 0, 1, 0, 0));
    cpu_rd(2'd2, rd);
    bus_stop();
    cpu_rd(2'd0, rd); check("R6 gcall cleared by stop", rd, exp_reg(3'b111, 0, 0, 0, 0, 0));

    // foreign address
    other = 7'($urandom());
    while (other == own || other == 7'h00) other = 7'($urandom());
    bus_start();
    send_byte({other, 1'b0}, ack);
    check("R5 no ack on other address", {7'd0, ack}, 8'h01);
    check("R5 no irq on other address", {7'd0, irq}, 8'h00);
    cpu_rd(2'd0, rd); check("R5 hit clear on other address", rd, exp_reg(3'b111, 0, 0, 1, 0, 0));
    bus_stop();

    // acknowledge disabled
    cpu_wr(2'd0, 8'h60);
    bus_start();
    send_byte({own, 1'b0}, ack);
    check("R8 no ack when disabled", {7'd0, ack}, 8'h01);
    cpu_rd(2'd0, rd); check("R9 nack seen on own slot", rd, exp_reg(3'b011, 0, 0, 1, 1, 1));
    cpu_rd(2'd2, rd);
    b = 8'($urandom());
    send_byte(b, ack);
    check("R8 no data ack when disabled", {7'd0, ack}, 8'h01);
    cpu_rd(2'd2, rd); check("R11 byte received without ack", rd, b);
    bus_stop();

    // interrupt disabled
    cpu_wr(2'd0, 8'hC0);
    bus_start();
    send_byte({own, 1'b0}, ack);
    check("R10 no irq or hold when disabled", {6'd0, irq, scl_low}, 8'h00);
    b = 8'($urandom());
    send_byte(b, ack);
    check("R10 no irq after data", {6'd0, irq, scl_low}, 8'h00);
    cpu_rd(2'd2, rd); check("R11 data without irq", rd, b);
    bus_stop();

    // module disabled
    cpu_wr(2'd0, 8'hA0);
    bus_start();
    cpu_rd(2'd0, rd); check("R3 no busy when disabled", rd, 8'hA0);
    send_byte({own, 1'b0}, ack);
    check("R3 no ack when disabled", {7'd0, ack}, 8'h01);
    check("R3 no irq when disabled", {6'd0, irq, scl_low}, 8'h00);
    bus_stop();

    finish_run();
  end
endmodule